// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache

This block is a data cache that sits between a processor-side request port and a slower main-memory port. Each address can live in any one of four ways of the set it indexes. The tags of all four ways are compared in the same cycle. A hit completes in the same cycle it is presented. A miss holds the requester until the line has been brought in from memory. The line size is 16 bytes, and memory moves it as four 32-bit beats in ascending word order.

Reads and writes both allocate. A write that hits changes only the cached copy and marks it dirty. A write that misses first fetches the line, then merges the write data under byte enables. Replacement always evicts the least recently used way of the set. A dirty victim is burst back to memory before the refill begins.

A snoop input reports writes made by other bus masters. Any matching cached line is invalidated, so the next processor access to it misses and reloads. After reset the block walks the sets one per cycle to clear their valid bits and seed the age order. It refuses processor requests until that walk is done.

Top module: `wb_cache4`

## Requirements
- R1: After reset the block spends one cycle per set clearing valid bits; during those SETS cycles cpu_ready and mem_req stay low.
- R2: Address bits [3:0] select the byte in the line, the next log2(SETS) bits select the set, and the remaining upper bits form the tag; SETS may only be 128 or 256.
- R3: A request whose tag matches a valid way of its set gets cpu_ready in the same cycle, with read data from that line and no memory traffic.
- R4: A miss keeps cpu_ready low while a four-beat 32-bit read burst fetches the line from its 16-byte base in ascending word order; each beat completes on mem_ack, with mem_addr and mem_we held in between.
- R5: A write hit merges cpu_wdata into the cached word under cpu_be (bit n enables byte lane n) and produces no memory write.
- R6: A write miss first fetches the line, then merges the write data under cpu_be; the untouched bytes hold the memory contents.
- R7: The victim of a miss is the least recently used way of the set; every hit and every fill makes the accessed way the most recent.
- R8: A dirty victim is written to memory as a four-beat burst immediately before the refill burst; a clean victim causes no write.
- R9: A snoop whose address matches a valid line invalidates it; the next processor access to that address misses and reloads from memory.
- R10: A snoop to an address that is not cached leaves every line in the set usable.
- R11: A snoop that matches the line being refilled makes that fill end invalid, so the pending request fetches the line again.
- R12: A snoop that matches a victim during its writeback does not cut the writeback short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory burst in progress |
| mem_we | output | 1 | Current burst is a write |
| mem_addr | output | ADDR_W | Word address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_ack | input | 1 | Current beat completes this cycle |
| mem_rdata | input | 32 | Read data of the current beat |
| snp_valid | input | 1 | A foreign bus-master write is observed |
| snp_addr | input | ADDR_W | Address of the observed write |

## Verification
The bench builds the cache with SETS = 128 and a 32-bit address, so the tag starts at bit 11. Addresses 2 KiB apart therefore land in the same set. Five or more such addresses are enough to fill a set, force evictions in a known LRU order and push dirty lines back to memory. The memory model acknowledges every other cycle, which leaves whole cycles inside the writeback and refill bursts where a snoop can be placed. The 256-set variant is reached only through elaboration with the other permitted value.

// File: rtl/wb_cache4_pkg.sv
package wb_cache4_pkg;
   localparam int WAYS   = 4;
   localparam int WAY_W  = 2;
   localparam int WORD_W = 32;
   localparam int BE_W   = WORD_W / 8;
   localparam int BEATS  = 4;
   localparam int BEAT_W = 2;
   localparam int OFS_W  = 4;

   typedef enum logic [1:0] {
      ST_INIT  = 2'd0,
      ST_IDLE  = 2'd1,
      ST_WBACK = 2'd2,
      ST_FILL  = 2'd3
   } ctl_state_t;
endpackage

// File: rtl/wb_cache4_tags.sv
module wb_cache4_tags
   import wb_cache4_pkg::*;
#(
   parameter int SETS  = 128,
   parameter int TAG_W = 21,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic                        clk,
   input  logic [IDX_W-1:0]            lk_idx,
   input  logic [TAG_W-1:0]            lk_tag,
   output logic [WAYS-1:0]             lk_hit,
   output logic [WAYS-1:0]             lk_valid,
   output logic [WAYS-1:0]             lk_dirty,
   output logic [WAYS-1:0][TAG_W-1:0]  lk_tags,
   input  logic                        sn_en,
   input  logic [IDX_W-1:0]            sn_idx,
   input  logic [TAG_W-1:0]            sn_tag,
   output logic [WAYS-1:0]             sn_hit,
   input  logic                        clr_en,
   input  logic [IDX_W-1:0]            clr_idx,
   input  logic                        fill_en,
   input  logic [IDX_W-1:0]            fill_idx,
   input  logic [WAY_W-1:0]            fill_way,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic                        fill_valid,
   input  logic                        dty_en,
   input  logic [IDX_W-1:0]            dty_idx,
   input  logic [WAY_W-1:0]            dty_way
);
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAYS-1:0]  dty_q [SETS];

   assign lk_valid = vld_q[lk_idx];
   assign lk_dirty = dty_q[lk_idx];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign lk_tags[w] = tag_q[lk_idx][w];
      assign lk_hit[w]  = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
      assign sn_hit[w]  = sn_en && vld_q[sn_idx][w] && (tag_q[sn_idx][w] == sn_tag);
   end

   always_ff @(posedge clk) begin
      if (clr_en) begin
         vld_q[clr_idx] <= '0;
         dty_q[clr_idx] <= '0;
      end
      if (fill_en) begin
         tag_q[fill_idx][fill_way] <= fill_tag;
         vld_q[fill_idx][fill_way] <= fill_valid;
         dty_q[fill_idx][fill_way] <= 1'b0;
      end
      if (dty_en) begin
         dty_q[dty_idx][dty_way] <= 1'b1;
      end
      for (int w = 0; w < WAYS; w++) begin
         if (sn_hit[w] && !(fill_en && (fill_idx == sn_idx) && (fill_way == WAY_W'(w)))) begin
            vld_q[sn_idx][w] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wb_cache4_lru.sv
module wb_cache4_lru
   import wb_cache4_pkg::*;
#(
   parameter int SETS = 128,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             init_en,
   input  logic [IDX_W-1:0] init_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WAY_W-1:0] victim,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [WAY_W-1:0] touch_way
);
   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0] rd_age, cur_age, nxt_age, seed_age;
   logic [WAY_W-1:0]           ref_age;

   assign rd_age  = age_q[rd_idx];
   assign cur_age = age_q[touch_idx];
   assign ref_age = cur_age[touch_way];

   for (genvar w = 0; w < WAYS; w++) begin : g_age
      assign seed_age[w] = WAY_W'(w);
      assign nxt_age[w]  = (touch_way == WAY_W'(w)) ? '0 :
                           (cur_age[w] < ref_age)   ? WAY_W'(cur_age[w] + 1'b1) :
                                                      cur_age[w];
   end

   always_comb begin
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rd_age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
   end

   always_ff @(posedge clk) begin
      if (init_en)       age_q[init_idx]  <= seed_age;
      else if (touch_en) age_q[touch_idx] <= nxt_age;
   end
endmodule

// File: rtl/wb_cache4_data.sv
module wb_cache4_data
   import wb_cache4_pkg::*;
#(
   parameter int SETS = 128,
   localparam int IDX_W = $clog2(SETS),
   localparam int AW    = IDX_W + WAY_W + BEAT_W,
   localparam int DEPTH = SETS * WAYS * BEATS
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [BE_W-1:0]   wr_be
);
   logic [WORD_W-1:0] mem_q [DEPTH];

   assign rd_data = mem_q[rd_addr];

   always_ff @(posedge clk) begin
      for (int b = 0; b < BE_W; b++) begin
         if (wr_en && wr_be[b]) mem_q[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
      end
   end
endmodule

// File: rtl/wb_cache4.sv
module wb_cache4
   import wb_cache4_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SETS   = 128,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   input  logic [3:0]        cpu_be,
   output logic [31:0]       cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr
);
   localparam int DA_W = IDX_W + WAY_W + BEAT_W;

   if (!(SETS == 128 || SETS == 256)) begin : g_bad_sets
      $error("wb_cache4: SETS must be 128 or 256");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("wb_cache4: ADDR_W too narrow for the chosen SETS");
   end

   ctl_state_t        state_q;
   logic [IDX_W-1:0]  init_idx_q, rq_idx_q;
   logic [TAG_W-1:0]  rq_tag_q, vtag_q;
   logic [WAY_W-1:0]  way_q, hit_way, victim;
   logic [BEAT_W-1:0] beat_q;
   logic              kill_q;

   logic [IDX_W-1:0]  c_idx, s_idx;
   logic [TAG_W-1:0]  c_tag, s_tag;
   logic [BEAT_W-1:0] c_word;
   logic [WAYS-1:0]   lk_hit, lk_valid, lk_dirty, sn_hit;
   logic [WAYS-1:0][TAG_W-1:0] lk_tags;
   logic              hit, in_idle, in_wb, in_fill, fill_last, snp_refill;
   logic              wr_en;
   logic [DA_W-1:0]   rd_addr, wr_addr;
   logic [31:0]       rd_data, wr_data;
   logic [3:0]        wr_be;
   logic              touch_en;
   logic [IDX_W-1:0]  touch_idx;
   logic [WAY_W-1:0]  touch_way;
   logic              unused_bits;

   assign unused_bits = ^{cpu_addr[1:0], snp_addr[OFS_W-1:0]};

   assign c_idx  = cpu_addr[OFS_W +: IDX_W];
   assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign c_word = cpu_addr[3:2];
   assign s_idx  = snp_addr[OFS_W +: IDX_W];
   assign s_tag  = snp_addr[ADDR_W-1 -: TAG_W];

   assign in_idle = (state_q == ST_IDLE);
   assign in_wb   = (state_q == ST_WBACK);
   assign in_fill = (state_q == ST_FILL);

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_hit[w]) hit_way = WAY_W'(w);
      end
   end
   assign hit = |lk_hit;

   assign cpu_ready  = in_idle && cpu_req && hit;
   assign snp_refill = snp_valid && in_fill && (s_idx == rq_idx_q) && (s_tag == rq_tag_q);
   assign fill_last  = in_fill && mem_ack && (beat_q == BEAT_W'(BEATS - 1));

   assign rd_addr   = in_wb ? {rq_idx_q, way_q, beat_q} : {c_idx, hit_way, c_word};
   assign cpu_rdata = rd_data;
   assign wr_en     = (cpu_ready && cpu_we) || (in_fill && mem_ack);
   assign wr_addr   = in_fill ? {rq_idx_q, way_q, beat_q} : {c_idx, hit_way, c_word};
   assign wr_data   = in_fill ? mem_rdata : cpu_wdata;
   assign wr_be     = in_fill ? '1 : cpu_be;

   assign touch_en  = cpu_ready || fill_last;
   assign touch_idx = in_fill ? rq_idx_q : c_idx;
   assign touch_way = in_fill ? way_q : hit_way;

   assign mem_req   = in_wb || in_fill;
   assign mem_we    = in_wb;
   assign mem_addr  = in_wb ? {vtag_q, rq_idx_q, beat_q, 2'b00}
                            : {rq_tag_q, rq_idx_q, beat_q, 2'b00};
   assign mem_wdata = rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_INIT;
         init_idx_q <= '0;
         rq_idx_q   <= '0;
         rq_tag_q   <= '0;
         vtag_q     <= '0;
         way_q      <= '0;
         beat_q     <= '0;
         kill_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_INIT: begin
               init_idx_q <= init_idx_q + 1'b1;
               if (init_idx_q == IDX_W'(SETS - 1)) state_q <= ST_IDLE;
            end
            ST_IDLE: begin
               if (cpu_req && !hit) begin
                  rq_idx_q <= c_idx;
                  rq_tag_q <= c_tag;
                  way_q    <= victim;
                  vtag_q   <= lk_tags[victim];
                  beat_q   <= '0;
                  kill_q   <= 1'b0;
                  state_q  <= (lk_valid[victim] && lk_dirty[victim]) ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == BEAT_W'(BEATS - 1)) state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (snp_refill) kill_q <= 1'b1;
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == BEAT_W'(BEATS - 1)) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_INIT;
         endcase
      end
   end

   wb_cache4_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .lk_idx     (c_idx),
      .lk_tag     (c_tag),
      .lk_hit     (lk_hit),
      .lk_valid   (lk_valid),
      .lk_dirty   (lk_dirty),
      .lk_tags    (lk_tags),
      .sn_en      (snp_valid),
      .sn_idx     (s_idx),
      .sn_tag     (s_tag),
      .sn_hit     (sn_hit),
      .clr_en     (state_q == ST_INIT),
      .clr_idx    (init_idx_q),
      .fill_en    (fill_last),
      .fill_idx   (rq_idx_q),
      .fill_way   (way_q),
      .fill_tag   (rq_tag_q),
      .fill_valid (!(kill_q || snp_refill)),
      .dty_en     (cpu_ready && cpu_we),
      .dty_idx    (c_idx),
      .dty_way    (hit_way)
   );

   wb_cache4_lru #(.SETS(SETS)) u_lru (
      .clk       (clk),
      .init_en   (state_q == ST_INIT),
      .init_idx  (init_idx_q),
      .rd_idx    (c_idx),
      .victim    (victim),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .touch_way (touch_way)
   );

   wb_cache4_data #(.SETS(SETS)) u_data (
      .clk     (clk),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_be   (wr_be)
   );
endmodule

// File: rtl/wb_cache4_chk.sv
module wb_cache4_chk #(
   parameter int ADDR_W = 32,
   parameter int SETS   = 128,
   localparam int CNT_W = $clog2(SETS) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr
);
   logic [CNT_W-1:0] since_rst;
   logic             in_init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       since_rst <= '0;
      else if (in_init) since_rst <= since_rst + 1'b1;
   end
   assign in_init = (since_rst < CNT_W'(SETS));

   p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_init |-> (!cpu_ready && !mem_req));

   p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_beat_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && (mem_addr[3:2] != 2'b11)) |=>
         (mem_req && (mem_we == $past(mem_we)) &&
          (mem_addr[3:2] == 2'($past(mem_addr[3:2]) + 2'd1))));

   p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack && (mem_addr[3:2] == 2'b11)) |=> (mem_req && !mem_we));

   p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind wb_cache4 wb_cache4_chk #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr)
);

// File: tb/tb_wb_cache4.sv
`timescale 1ns/1ps
module tb_wb_cache4;
   localparam int SETS   = 128;
   localparam int ADDR_W = 32;
   localparam int NVEC   = 17;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cpu_req, cpu_we;
   logic [ADDR_W-1:0] cpu_addr;
   logic [31:0]       cpu_wdata, cpu_rdata;
   logic [3:0]        cpu_be;
   logic              cpu_ready;
   logic              mem_req, mem_we, mem_ack;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_wdata, mem_rdata;
   logic              snp_valid;
   logic [ADDR_W-1:0] snp_addr;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   wbeats, rbeats;
   logic order_bad;
   logic [31:0] mm [logic [31:0]];
   logic [31:0] sh [logic [31:0]];

   always #10 clk = ~clk;

   wb_cache4 #(.ADDR_W(ADDR_W), .SETS(SETS)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .snp_valid(snp_valid), .snp_addr(snp_addr)
   );

   function automatic logic [31:0] base_val(input logic [31:0] a);
      return {a[15:0], ~a[15:0]};
   endfunction

   function automatic logic [31:0] mm_rd(input logic [31:0] a);
      return mm.exists(a) ? mm[a] : base_val(a);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [31:0] a);
      return sh.exists(a) ? sh[a] : base_val(a);
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // memory model: one beat every other cycle, counts beats per access
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_req === 1'b1 && !mem_ack) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               mm[mem_addr] = mem_wdata;
               wbeats++;
               if (rbeats > 0) order_bad = 1'b1;
            end else begin
               mem_rdata = mm_rd(mem_addr);
               rbeats++;
            end
         end else begin
            mem_ack = 1'b0;
         end
      end
   end

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                         input logic [3:0] be, output logic [31:0] rd, output int waits);
      logic [31:0] old;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
      wbeats = 0; rbeats = 0; order_bad = 1'b0;
      #1;
      waits = 0;
      while (cpu_ready !== 1'b1) begin
         @(negedge clk); #1;
         waits++;
         if (waits > 5000) break;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
      if (we) begin
         old = exp_rd(a);
         for (int b = 0; b < 4; b++) if (be[b]) old[8*b +: 8] = wd[8*b +: 8];
         sh[a] = old;
      end
   endtask

   task automatic snoop_pulse(input logic [31:0] a);
      @(negedge clk);
      snp_valid = 1'b1; snp_addr = a;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wd;
      logic [3:0]  be;
      logic        hit;
      logic [2:0]  wb;
   } vec_t;

   // set 5, tags 2 KiB apart (R2); LRU order traced per row (R7)
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 32'h0000_0050, 32'h0,         4'hF, 1'b0, 3'd0}, // A0 miss (R4)
      '{1'b0, 32'h0000_0050, 32'h0,         4'hF, 1'b1, 3'd0}, // A0 hit (R3)
      '{1'b1, 32'h0000_0054, 32'h1122_3344, 4'hF, 1'b1, 3'd0}, // write hit, no mem write (R5)
      '{1'b0, 32'h0000_0054, 32'h0,         4'hF, 1'b1, 3'd0},
      '{1'b0, 32'h0000_0850, 32'h0,         4'hF, 1'b0, 3'd0}, // A1
      '{1'b0, 32'h0000_1050, 32'h0,         4'hF, 1'b0, 3'd0}, // A2
      '{1'b0, 32'h0000_1850, 32'h0,         4'hF, 1'b0, 3'd0}, // A3, set full
      '{1'b0, 32'h0000_0054, 32'h0,         4'hF, 1'b1, 3'd0}, // A0 becomes MRU
      '{1'b0, 32'h0000_2050, 32'h0,         4'hF, 1'b0, 3'd0}, // A4 evicts A1 (clean)
      '{1'b0, 32'h0000_0850, 32'h0,         4'hF, 1'b0, 3'd0}, // A1 miss, evicts A2
      '{1'b0, 32'h0000_0054, 32'h0,         4'hF, 1'b1, 3'd0}, // A0 survived (R7)
      '{1'b1, 32'h0000_2858, 32'hDEAD_BEEF, 4'h3, 1'b0, 3'd0}, // write miss allocates (R6)
      '{1'b0, 32'h0000_2858, 32'h0,         4'hF, 1'b1, 3'd0}, // merged word
      '{1'b0, 32'h0000_4050, 32'h0,         4'hF, 1'b0, 3'd0}, // A8 evicts A4
      '{1'b0, 32'h0000_4850, 32'h0,         4'hF, 1'b0, 3'd0}, // A9 evicts A1
      '{1'b0, 32'h0000_5050, 32'h0,         4'hF, 1'b0, 3'd4}, // A10 evicts dirty A0 (R8)
      '{1'b0, 32'h0000_0054, 32'h0,         4'hF, 1'b0, 3'd4}  // A0 reload, evicts dirty A5
   };

   initial begin
      #(20 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd, exp;
      int          waits;
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
      cpu_wdata = '0; cpu_be = '0; snp_valid = 1'b0; snp_addr = '0;
      wbeats = 0; rbeats = 0; order_bad = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 ready low in reset", {31'b0, cpu_ready}, 32'd0);
      chk("R1 no mem traffic in reset", {31'b0, mem_req}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R1: request right after reset waits out the clearing walk
      access(1'b0, 32'h0000_0140, 32'h0, 4'hF, rd, waits);
      chk("R1 init stall", {31'b0, (waits >= SETS)}, 32'd1);
      chk("R4 data after init", rd, exp_rd(32'h0000_0140));

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         exp = exp_rd(VEC[i].addr);
         access(VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].be, rd, waits);
         chk(VEC[i].hit ? "R3 zero-wait hit" : "R4 miss stall",
             {31'b0, (waits == 0)}, {31'b0, VEC[i].hit});
         chk("R4 refill beats", rbeats, VEC[i].hit ? 32'd0 : 32'd4);
         chk(VEC[i].we ? "R5 no write-through" : "R8 writeback beats", wbeats, {29'b0, VEC[i].wb});
         chk("R8 writeback before refill", {31'b0, order_bad}, 32'd0);
         if (!VEC[i].we) chk("R6/R7 read data", rd, exp);
      end
      chk("R8 dirty A0 in memory", mm_rd(32'h0000_0054), 32'h1122_3344);
      chk("R6 merged A5 in memory", mm_rd(32'h0000_2858),
          {base_val(32'h0000_2858)[31:16], 16'hBEEF});

      // R2: a different index is untouched by set-5 traffic
      access(1'b0, 32'h0000_0140, 32'h0, 4'hF, rd, waits);
      chk("R2 separate set keeps line", {31'b0, (waits == 0)}, 32'd1);

      // R10: snoop to an uncached tag in the same set
      access(1'b0, 32'h0000_0090, 32'h0, 4'hF, rd, waits);
      snoop_pulse(32'h0000_0890);
      access(1'b0, 32'h0000_0090, 32'h0, 4'hF, rd, waits);
      chk("R10 unrelated snoop keeps hit", {31'b0, (waits == 0)}, 32'd1);

      // R9: foreign write invalidates, next access reloads
      mm[32'h0000_0090] = 32'hCAFE_F00D;
      sh[32'h0000_0090] = 32'hCAFE_F00D;
      snoop_pulse(32'h0000_0090);
      access(1'b0, 32'h0000_0090, 32'h0, 4'hF, rd, waits);
      chk("R9 snooped line misses", {31'b0, (waits == 0)}, 32'd0);
      chk("R9 reload data", rd, 32'hCAFE_F00D);

      // R11: snoop during refill of the same line forces a second fill
      fork
         access(1'b0, 32'h0000_00D0, 32'h0, 4'hF, rd, waits);
         begin
            do @(negedge clk); while (!(mem_req === 1'b1 && mem_we === 1'b0));
            snp_valid = 1'b1; snp_addr = 32'h0000_00D0;
            @(negedge clk);
            snp_valid = 1'b0;
         end
      join
      chk("R11 refill repeated", rbeats, 32'd8);
      chk("R11 data", rd, exp_rd(32'h0000_00D0));
      access(1'b0, 32'h0000_00D0, 32'h0, 4'hF, rd, waits);
      chk("R11 line valid after clean fill", {31'b0, (waits == 0)}, 32'd1);

      // R12: snoop on a victim during its writeback
      access(1'b1, 32'h0000_00E0, 32'h0BAD_F00D, 4'hF, rd, waits);
      access(1'b0, 32'h0000_08E0, 32'h0, 4'hF, rd, waits);
      access(1'b0, 32'h0000_10E0, 32'h0, 4'hF, rd, waits);
      access(1'b0, 32'h0000_18E0, 32'h0, 4'hF, rd, waits);
      fork
         access(1'b0, 32'h0000_20E0, 32'h0, 4'hF, rd, waits);
         begin
            do @(negedge clk); while (!(mem_req === 1'b1 && mem_we === 1'b1));
            snp_valid = 1'b1; snp_addr = 32'h0000_00E0;
            @(negedge clk);
            snp_valid = 1'b0;
         end
      join
      chk("R12 writeback completes", wbeats, 32'd4);
      chk("R12 victim data in memory", mm_rd(32'h0000_00E0), 32'h0BAD_F00D);
      access(1'b0, 32'h0000_00E0, 32'h0, 4'hF, rd, waits);
      chk("R12 reload written-back data", rd, 32'h0BAD_F00D);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule